// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block sits beside an 8-bit processor core and decides, at every instruction boundary, whether to divert execution to an interrupt service routine. It watches five request lines. One is a non-maskable trap. Three are maskable restart lines at levels 7.5, 6.5 and 5.5. The last is a general request whose target the requesting device supplies. When the core signals a boundary, the controller picks the single highest-priority eligible request and issues a response word on a valid/ready stream. The word carries either a fixed restart address or, for the general request, an acknowledge marker.

The core drives four command inputs. Three are strobes (enable, disable and set-mask), and the set-mask strobe comes with an 8-bit command word taken from the accumulator. The fourth command, read-mask, needs no strobe: the packed read-mask word is always available on a status output. One serial-out bit is held for the core. Once the controller raises `resp_valid`, it keeps the vector and the flag unchanged until the consumer asserts `resp_ready`. While a response is outstanding it does not arbitrate, so back-pressure delays the next acceptance and no request is lost. Latched requests stay latched, and level requests are re-evaluated at the next boundary after the handshake.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset no response is valid, the enable flag is clear, all three masks are set, the 7.5 latch and the trap latch are empty and `serial_out` is 0. With all lines low and `serial_in` at 0, `mask_status` therefore reads 07h.
- R2: Fixed priority, highest first: trap, 7.5, 6.5, 5.5, general request. Only the winner is answered at a boundary.
- R3: Response vectors are 8 times the restart number: trap 24h, 7.5 3Ch, 6.5 34h, 5.5 2Ch, each with `resp_gen` = 0.
- R4: A general request is answered with `resp_gen` = 1 and `resp_vector` = 00h.
- R5: The trap is answered whatever the enable flag and the masks hold.
- R6: The trap needs a rising edge, and the line must still be high at the boundary. A pulse that falls before the boundary is dropped, and a line held high is answered once only.
- R7: A rising edge on the 7.5 line is latched, even while 7.5 is masked, and stays pending after the line falls. The latch is cleared when 7.5 is answered or by a set-mask word with bit 4 set. A new edge in the same cycle as a clear wins.
- R8: The 6.5 and 5.5 lines and the general request are level-sensitive and are sampled only at the boundary.
- R9: Enable sets the flag, but the boundary ending the enabling instruction is still closed to maskable requests; the next boundary is open. Disable and reset clear the flag. Maskable requests and the general request are answered only while the flag is set.
- R10: Answering any request other than the trap clears the enable flag.
- R11: In the set-mask word, bit 3 enables the mask write. When it is set, bits 0, 1 and 2 become the masks for 5.5, 6.5 and 7.5, where 1 means masked. Bit 4 clears the 7.5 latch. Bit 6 enables loading bit 7 into `serial_out`. Without bit 3 the masks are untouched, and without bit 6 `serial_out` is untouched.
- R12: `mask_status` packs the masks for 5.5, 6.5 and 7.5 in bits 0 to 2 and the enable flag in bit 3. Bits 4 and 5 carry the 5.5 and 6.5 line levels, bit 6 the 7.5 latch and bit 7 `serial_in`.
- R13: A response appears only after a boundary cycle. It stays valid with a stable vector and flag until `resp_ready` is sampled high, and no new request is taken while one is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_done | input | 1 | High for one cycle at each instruction boundary |
| trap_in | input | 1 | Non-maskable trap line |
| rst75_in | input | 1 | Edge-latched restart 7.5 line |
| rst65_in | input | 1 | Level restart 6.5 line |
| rst55_in | input | 1 | Level restart 5.5 line |
| gen_req_in | input | 1 | General request line, level |
| cmd_ei | input | 1 | Enable-interrupts strobe |
| cmd_di | input | 1 | Disable-interrupts strobe |
| cmd_sim | input | 1 | Set-mask strobe |
| cmd_word | input | 8 | Set-mask command word |
| serial_in | input | 1 | Serial input bit reported in the status word |
| resp_ready | input | 1 | Consumer accepts the response |
| resp_valid | output | 1 | Response word is valid |
| resp_vector | output | 8 | Restart address, 00h for the general request |
| resp_gen | output | 1 | Response acknowledges the general request |
| mask_status | output | 8 | Read-mask word |
| serial_out | output | 1 | Serial output bit |

## Verification
A response is due one clock edge after the boundary cycle that takes it. It stays until the edge at which `resp_ready` is high, so a boundary driven between two falling edges shows its result at the next falling edge. The status bits that come from registers (masks, enable flag, 7.5 latch) change one edge after the command or line event. The 6.5/5.5 level bits and the serial input bit follow their inputs in the same cycle. For that reason the reference model advances on every rising edge and is compared a quarter period later, with the level bits taken from the inputs as driven. A trap or 7.5 edge needs one edge to be latched before a boundary can answer it, and the directed sequences leave that cycle in before each boundary.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int WORD_W = 8;
  localparam int VEC_W  = 8;
  localparam int N_RST  = 3;
  localparam int N_REQ  = N_RST + 1;

  // set-mask command word fields
  localparam int F_MASK_EN = 3;
  localparam int F_CLR75   = 4;
  localparam int F_SO_EN   = 6;
  localparam int F_SO_DAT  = 7;

  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_TRAP = 3'd1,
    SRC_R75  = 3'd2,
    SRC_R65  = 3'd3,
    SRC_R55  = 3'd4,
    SRC_GEN  = 3'd5
  } src_e;

  function automatic logic [VEC_W-1:0] restart_addr(input int unsigned num);
    return VEC_W'(8 * num + 4);
  endfunction

  localparam logic [VEC_W-1:0] VEC_TRAP = restart_addr(4);
  localparam logic [VEC_W-1:0] VEC_R75  = restart_addr(7);
  localparam logic [VEC_W-1:0] VEC_R65  = restart_addr(6);
  localparam logic [VEC_W-1:0] VEC_R55  = restart_addr(5);
endpackage

// File: rtl/pic_edge_latch.sv
module pic_edge_latch #(
  parameter bit LEVEL_QUAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  input  logic clr_i,
  output logic act_o
);
  logic prev_q, pend_q, pend_d, rise;

  assign rise = line_i & ~prev_q;

  generate
    if (LEVEL_QUAL) begin : g_level
      // line must stay high: dropping it discards the capture
      assign pend_d = line_i & (rise | (pend_q & ~clr_i));
      assign act_o  = pend_q & line_i;
    end else begin : g_edge
      // a new edge wins over a coincident clear
      assign pend_d = rise | (pend_q & ~clr_i);
      assign act_o  = pend_q;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= line_i;
      pend_q <= pend_d;
    end
  end
endmodule

// File: rtl/pic_mask_ctrl.sv
module pic_mask_ctrl
  import pic_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_done,
  input  logic              cmd_ei,
  input  logic              cmd_di,
  input  logic              cmd_sim,
  input  logic [WORD_W-1:0] cmd_word,
  input  logic              take_mask,
  output logic              ie_o,
  output logic              open_o,
  output logic [N_RST-1:0]  mask_o,
  output logic              sod_o
);
  logic             ie_q, shadow_q, sod_q;
  logic [N_RST-1:0] mask_q;

  // enable only opens after the boundary of the enabling instruction
  assign open_o = ie_q & ~shadow_q & ~cmd_ei;
  assign ie_o   = ie_q;
  assign mask_o = mask_q;
  assign sod_o  = sod_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q     <= 1'b0;
      shadow_q <= 1'b0;
      mask_q   <= '1;
      sod_q    <= 1'b0;
    end else begin
      if (take_mask)   ie_q <= 1'b0;
      else if (cmd_di) ie_q <= 1'b0;
      else if (cmd_ei) ie_q <= 1'b1;

      if (cmd_ei && !instr_done) shadow_q <= 1'b1;
      else if (instr_done)       shadow_q <= 1'b0;

      if (cmd_sim && cmd_word[F_MASK_EN]) mask_q <= cmd_word[N_RST-1:0];
      if (cmd_sim && cmd_word[F_SO_EN])   sod_q  <= cmd_word[F_SO_DAT];
    end
  end
endmodule

// File: rtl/pic_prio_arb.sv
module pic_prio_arb
  import pic_pkg::*;
#(
  parameter int NREQ = N_REQ
) (
  input  logic            trap_act,
  input  logic            open_i,
  input  logic [NREQ-1:0] req_i,   // index 0 is the highest maskable level
  output src_e            win_o
);
  always_comb begin
    win_o = SRC_NONE;
    if (trap_act) begin
      win_o = SRC_TRAP;
    end else if (open_i) begin
      for (int i = NREQ - 1; i >= 0; i--) begin
        if (req_i[i]) win_o = src_e'(3'(i + 2));
      end
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pic_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_done,
  input  logic              trap_in,
  input  logic              rst75_in,
  input  logic              rst65_in,
  input  logic              rst55_in,
  input  logic              gen_req_in,
  input  logic              cmd_ei,
  input  logic              cmd_di,
  input  logic              cmd_sim,
  input  logic [WORD_W-1:0] cmd_word,
  input  logic              serial_in,
  input  logic              resp_ready,
  output logic              resp_valid,
  output logic [VEC_W-1:0]  resp_vector,
  output logic              resp_gen,
  output logic [WORD_W-1:0] mask_status,
  output logic              serial_out
);
  logic             trap_act, p75, ie, open_g, take, take_mask, clr75, clr_trap;
  logic [N_RST-1:0] mask;
  logic [N_REQ-1:0] req;
  logic             valid_q, gen_q;
  logic [VEC_W-1:0] vec_q, vec_d;
  src_e             win;
  logic             unused_word_bits;

  assign unused_word_bits = cmd_word[5];

  assign take      = instr_done & ~valid_q & (win != SRC_NONE);
  assign take_mask = take & (win != SRC_TRAP);
  assign clr_trap  = take & (win == SRC_TRAP);
  assign clr75     = (take & (win == SRC_R75)) | (cmd_sim & cmd_word[F_CLR75]);

  pic_edge_latch #(.LEVEL_QUAL(1'b1)) u_trap (
    .clk(clk), .rst_n(rst_n), .line_i(trap_in), .clr_i(clr_trap), .act_o(trap_act)
  );

  pic_edge_latch #(.LEVEL_QUAL(1'b0)) u_r75 (
    .clk(clk), .rst_n(rst_n), .line_i(rst75_in), .clr_i(clr75), .act_o(p75)
  );

  pic_mask_ctrl u_mask (
    .clk(clk), .rst_n(rst_n), .instr_done(instr_done), .cmd_ei(cmd_ei),
    .cmd_di(cmd_di), .cmd_sim(cmd_sim), .cmd_word(cmd_word), .take_mask(take_mask),
    .ie_o(ie), .open_o(open_g), .mask_o(mask), .sod_o(serial_out)
  );

  assign req = {gen_req_in, rst55_in & ~mask[0], rst65_in & ~mask[1], p75 & ~mask[2]};

  pic_prio_arb #(.NREQ(N_REQ)) u_arb (
    .trap_act(trap_act), .open_i(open_g), .req_i(req), .win_o(win)
  );

  always_comb begin
    unique case (win)
      SRC_TRAP: vec_d = VEC_TRAP;
      SRC_R75:  vec_d = VEC_R75;
      SRC_R65:  vec_d = VEC_R65;
      SRC_R55:  vec_d = VEC_R55;
      default:  vec_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      vec_q   <= '0;
      gen_q   <= 1'b0;
    end else if (take) begin
      valid_q <= 1'b1;
      vec_q   <= vec_d;
      gen_q   <= (win == SRC_GEN);
    end else if (valid_q && resp_ready) begin
      valid_q <= 1'b0;
    end
  end

  assign resp_valid  = valid_q;
  assign resp_vector = vec_q;
  assign resp_gen    = gen_q;
  assign mask_status = {serial_in, p75, rst65_in, rst55_in, ie, mask};
endmodule

// File: rtl/pic_ctrl_chk.sv
module pic_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       instr_done,
  input logic       trap_in,
  input logic       rst75_in,
  input logic       cmd_sim,
  input logic [7:0] cmd_word,
  input logic       resp_ready,
  input logic       resp_valid,
  input logic [7:0] resp_vector,
  input logic       resp_gen,
  input logic [7:0] mask_status,
  input logic       serial_out
);
  p_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_ready |=> resp_valid && $stable(resp_vector) && $stable(resp_gen));

  p_boundary_r13: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resp_valid) |-> $past(instr_done));

  p_gen_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_gen |-> resp_vector == 8'h00);

  p_vec_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_gen |-> (resp_vector == 8'h24 || resp_vector == 8'h3C ||
                                 resp_vector == 8'h34 || resp_vector == 8'h2C));

  p_ie_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resp_valid) && resp_vector != 8'h24 |-> !mask_status[3]);

  p_mask_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_sim && !cmd_word[3] |=> $stable(mask_status[2:0]));

  p_so_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_sim && cmd_word[6]) |=> $stable(serial_out));

  p_clr75_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_sim && cmd_word[4] && !rst75_in |=> !mask_status[6]);

  p_trap_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !resp_valid && !trap_in |=> !(resp_valid && !resp_gen && resp_vector == 8'h24));
endmodule

bind prio_irq_ctrl pic_ctrl_chk u_chk (.*);

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic instr_done = 0, trap_in = 0, rst75_in = 0, rst65_in = 0, rst55_in = 0, gen_req_in = 0;
  logic cmd_ei = 0, cmd_di = 0, cmd_sim = 0, serial_in = 0, resp_ready = 1;
  logic [7:0] cmd_word = 8'h00;
  logic resp_valid, resp_gen, serial_out;
  logic [7:0] resp_vector, mask_status;

  int n_tests = 0, n_fail = 0;
  bit started = 0, done = 0;

  always #(CLK_P/2) clk = ~clk;

  prio_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .instr_done(instr_done), .trap_in(trap_in),
    .rst75_in(rst75_in), .rst65_in(rst65_in), .rst55_in(rst55_in), .gen_req_in(gen_req_in),
    .cmd_ei(cmd_ei), .cmd_di(cmd_di), .cmd_sim(cmd_sim), .cmd_word(cmd_word),
    .serial_in(serial_in), .resp_ready(resp_ready), .resp_valid(resp_valid),
    .resp_vector(resp_vector), .resp_gen(resp_gen), .mask_status(mask_status),
    .serial_out(serial_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  bit       m_ie, m_sh, m_sod, m_p75, m_tp, m_tprev, m_rprev, m_valid, m_gen;
  bit [2:0] m_mask;
  bit [7:0] m_vec;
  int       win;
  bit       take, t_rise, r_rise, open;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ie = 0; m_sh = 0; m_sod = 0; m_p75 = 0; m_tp = 0; m_tprev = 0; m_rprev = 0;
      m_valid = 0; m_gen = 0; m_mask = 3'b111; m_vec = 8'h00;
    end else begin
      t_rise = trap_in && !m_tprev;
      r_rise = rst75_in && !m_rprev;
      open = m_ie && !m_sh && !cmd_ei;
      win = 0;
      if (m_tp && trap_in) win = 1;
      else if (open) begin
        if (m_p75 && !m_mask[2]) win = 2;
        else if (rst65_in && !m_mask[1]) win = 3;
        else if (rst55_in && !m_mask[0]) win = 4;
        else if (gen_req_in) win = 5;
      end
      take = instr_done && !m_valid && win != 0;
      if (m_valid && resp_ready) m_valid = 0;
      if (take) begin
        m_valid = 1;
        m_gen = (win == 5);
        case (win)
          1: m_vec = 8'h24;
          2: m_vec = 8'h3C;
          3: m_vec = 8'h34;
          4: m_vec = 8'h2C;
          default: m_vec = 8'h00;
        endcase
      end
      m_tp = trap_in && (t_rise || (m_tp && !(take && win == 1)));
      m_p75 = r_rise || (m_p75 && !((take && win == 2) || (cmd_sim && cmd_word[4])));
      if (take && win != 1) m_ie = 0;
      else if (cmd_di) m_ie = 0;
      else if (cmd_ei) m_ie = 1;
      if (cmd_ei && !instr_done) m_sh = 1;
      else if (instr_done) m_sh = 0;
      if (cmd_sim && cmd_word[3]) m_mask = cmd_word[2:0];
      if (cmd_sim && cmd_word[6]) m_sod = cmd_word[7];
      m_tprev = trap_in;
      m_rprev = rst75_in;
    end
  end

  always @(posedge clk) begin
    #(CLK_P/4);
    if (started && !done) begin
      chk("R13 model valid", 32'(resp_valid), 32'(m_valid));
      chk("R13 model vector", 32'(resp_vector), 32'(m_vec));
      chk("R13 model gen", 32'(resp_gen), 32'(m_gen));
      chk("R12 model status", 32'(mask_status),
          32'({serial_in, m_p75, rst65_in, rst55_in, m_ie, m_mask}));
      chk("R11 model serial out", 32'(serial_out), 32'(m_sod));
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic bnd();
    instr_done = 1; @(negedge clk); instr_done = 0;
  endtask
  task automatic ei();
    cmd_ei = 1; @(negedge clk); cmd_ei = 0;
  endtask
  task automatic di();
    cmd_di = 1; @(negedge clk); cmd_di = 0;
  endtask
  task automatic sim(input logic [7:0] w);
    cmd_sim = 1; cmd_word = w; @(negedge clk); cmd_sim = 0; cmd_word = 8'h00;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    idle(2);
    started = 1;
    chk("R1 reset valid", 32'(resp_valid), 0);
    chk("R1 reset status", 32'(mask_status), 32'h07);
    chk("R1 reset serial out", 32'(serial_out), 0);
    rst_n = 1;
    idle(1);

    // trap ignores disabled flag and masks
    trap_in = 1; idle(1); bnd();
    chk("R5 trap taken while disabled", 32'(resp_valid), 1);
    chk("R3 trap vector", 32'(resp_vector), 32'h24);
    bnd();
    chk("R6 trap held high answered once", 32'(resp_valid), 0);
    trap_in = 0; idle(1);
    // short trap pulse
    trap_in = 1; idle(1); trap_in = 0; bnd();
    chk("R6 trap pulse dropped", 32'(resp_valid), 0);

    // general request while disabled, then enable delay
    gen_req_in = 1; bnd();
    chk("R9 disabled ignores general", 32'(resp_valid), 0);
    ei();
    chk("R9 enable flag set", 32'(mask_status[3]), 1);
    bnd();
    chk("R9 enabling boundary closed", 32'(resp_valid), 0);
    bnd();
    chk("R4 general acknowledged", 32'(resp_gen), 1);
    chk("R4 general vector zero", 32'(resp_vector), 0);
    chk("R10 enable cleared on accept", 32'(mask_status[3]), 0);
    gen_req_in = 0; idle(1);

    // priority among level inputs
    sim(8'h08);
    chk("R11 masks cleared", 32'(mask_status[2:0]), 0);
    rst55_in = 1; rst65_in = 1;
    ei(); bnd(); bnd();
    chk("R2 6.5 over 5.5", 32'(resp_vector), 32'h34);
    ei(); bnd(); rst65_in = 0; bnd();
    chk("R3 5.5 vector", 32'(resp_vector), 32'h2C);
    rst55_in = 0; idle(1);
    // level dropped before boundary
    ei(); bnd(); rst65_in = 1; idle(1); rst65_in = 0; bnd();
    chk("R8 level dropped before boundary", 32'(resp_valid), 0);
    di(); idle(1);

    // 7.5 latch and priority
    rst75_in = 1; idle(1); rst75_in = 0; idle(1);
    chk("R7 7.5 latched after fall", 32'(mask_status[6]), 1);
    rst65_in = 1; rst55_in = 1; gen_req_in = 1;
    ei(); bnd(); bnd();
    chk("R2 7.5 over lower levels", 32'(resp_vector), 32'h3C);
    chk("R7 latch cleared on accept", 32'(mask_status[6]), 0);
    rst65_in = 0; rst55_in = 0; gen_req_in = 0; idle(1);
    rst75_in = 1; idle(1); rst75_in = 0; sim(8'h10);
    chk("R7 latch cleared by command", 32'(mask_status[6]), 0);
    chk("R11 masks kept without bit 3", 32'(mask_status[2:0]), 0);

    // mask write gating and mapping
    sim(8'h05);
    chk("R11 no write without bit 3", 32'(mask_status[2:0]), 0);
    sim(8'h0D);
    chk("R11 masks written", 32'(mask_status[2:0]), 32'h5);
    rst55_in = 1; ei(); bnd(); bnd();
    chk("R11 masked 5.5 ignored", 32'(resp_valid), 0);
    rst65_in = 1; bnd();
    chk("R11 unmasked 6.5 taken", 32'(resp_vector), 32'h34);
    rst55_in = 0; rst65_in = 0; idle(1);
    rst75_in = 1; idle(1); rst75_in = 0; idle(1);
    chk("R7 latched while masked", 32'(mask_status[6]), 1);
    sim(8'h18);
    chk("R7 cleared with mask write", 32'(mask_status[7:0]), 32'h00);

    // serial out
    sim(8'hC0);
    chk("R11 serial out set", 32'(serial_out), 1);
    sim(8'h80);
    chk("R11 serial out kept without bit 6", 32'(serial_out), 1);
    sim(8'h40);
    chk("R11 serial out cleared", 32'(serial_out), 0);

    // status packing
    serial_in = 1; rst65_in = 1; idle(1);
    chk("R12 status packing", 32'(mask_status), 32'hA0);
    serial_in = 0; rst65_in = 0; rst55_in = 1; idle(1);
    chk("R12 5.5 level bit", 32'(mask_status), 32'h10);
    rst55_in = 0;

    // disable
    ei(); bnd(); di(); gen_req_in = 1; bnd();
    chk("R9 disable blocks general", 32'(resp_valid), 0);
    gen_req_in = 0; idle(1);

    // back-pressure and trap over 7.5
    resp_ready = 0;
    ei(); bnd();
    rst75_in = 1; idle(1); rst75_in = 0;
    trap_in = 1; idle(1); bnd();
    chk("R2 trap over 7.5", 32'(resp_vector), 32'h24);
    idle(3);
    chk("R13 held valid", 32'(resp_valid), 1);
    gen_req_in = 1; bnd();
    chk("R13 no new take while pending", 32'(resp_vector), 32'h24);
    resp_ready = 1; idle(1);
    chk("R13 released", 32'(resp_valid), 0);
    bnd();
    chk("R13 pending 7.5 served next", 32'(resp_vector), 32'h3C);
    trap_in = 0; gen_req_in = 0; idle(3);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule